// File: doc/BRIEF.md
# Three-Phase Voltage Waveform Capture

This block sits at the end of the filtered phase-voltage datapath. Each time the upstream sample strobe fires (a fixed 8 kSPS cadence in the system), it takes one signed 24-bit value for each of the three phase voltages and latches all three together into holding registers. Software then reads them through a simple register port. Capture is a side tap: it never stalls the sample stream that continues to the power and rms engines.

Before capture, each phase can pass through a first-order DC-removal (high-pass) stage, or bypass it, under one configuration bit. A strobe raises a sticky ready flag, which software clears by writing one to it. A mask bit decides whether that flag pulls the active-low interrupt output. Samples read back sign-extended to 32 bits.

Top module: `wave_capture`

## Requirements
- R1: After reset, all three captured samples are zero, the ready flag and the mask bit are clear, the filter-enable bit (config bit 0) is 1, and `irq_n` is high.
- R2: On a cycle with `smp_valid` high, all three phase registers load on the same clock edge, and the new values are readable from the following cycle. Without a strobe they keep their values, whatever the sample inputs do.
- R3: With config bit 0 at 0 (bypass), each captured value equals the phase input present on the strobe cycle, bit for bit.
- R4: With config bit 0 at 1, each captured value is y = x - x_prev + y_prev - (y_prev >>> 10), where x_prev and y_prev are that phase's input and output at the previous strobe. While config bit 0 is 0, both are held at zero, so the first strobe after re-enabling starts from a zero state.
- R5: The filter output saturates to the signed 24-bit range [-8388608, 8388607] and does not wrap. The saturated value is the one stored as y_prev.
- R6: A strobe sets the ready flag, read at status bit 17. The flag stays set until it is cleared.
- R7: Writing the status register with bit 17 = 1 clears the ready flag. Writing it with bit 17 = 0 leaves the flag unchanged. If the clearing write and a strobe fall in the same cycle, the flag stays set.
- R8: The mask register bit 17 is read/write. `irq_n` is low exactly when the ready flag and the mask bit are both 1.
- R9: Address map: 0 = config (bit 0 only), 1 = status, 2 = mask, 4/5/6 = phase A/B/C sample. A sample reads as its 24-bit value sign-extended to 32 bits. Other bits read 0. Addresses 3 and 7 read 0. Read data is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_a | input | 24 | Phase A voltage sample, two's complement |
| smp_b | input | 24 | Phase B voltage sample, two's complement |
| smp_c | input | 24 | Phase C voltage sample, two's complement |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions take the strobe to be a single-cycle pulse, with config changes falling between strobes rather than on them. Under these conditions the filter's zero state and the bypass equality are well defined on the next edge. The interrupt-cause property assumes the mask changes only through a register write to address 2. The bench keeps every strobe one cycle wide and spaced by several read cycles, changes config only between strobes, and keeps sample inputs inside the signed 24-bit range. The only deliberate overlap is the strobe-with-clear collision.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int unsigned SMP_W   = 24;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NPH     = 3;
  localparam int unsigned LEAK_SH = 10;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned RDY_BIT = 17;
  localparam int unsigned EXT_W   = SMP_W + 3;

  localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_MASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_PH0  = ADDR_W'(4);

  typedef logic signed [SMP_W-1:0] smp_t;

  // One step of the leaky DC blocker, saturated to SMP_W bits
  function automatic smp_t dcb_step(input smp_t x, input smp_t xp, input smp_t yp);
    logic signed [EXT_W-1:0] acc;
    logic [EXT_W-SMP_W:0]    top;
    acc = EXT_W'(x) - EXT_W'(xp) + EXT_W'(yp) - EXT_W'(yp >>> LEAK_SH);
    top = acc[EXT_W-1:SMP_W-1];
    if (top == '0 || top == '1) return acc[SMP_W-1:0];
    else if (acc[EXT_W-1])      return {1'b1, {(SMP_W-1){1'b0}}};
    else                        return {1'b0, {(SMP_W-1){1'b1}}};
  endfunction

  function automatic logic [REG_W-1:0] sext(input smp_t s);
    return {{(REG_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction
endpackage

// File: rtl/wcap_dc_block.sv
module wcap_dc_block
  import wcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  smp_t x,
  output smp_t y
);
  smp_t x_prev, y_prev;

  assign y = dcb_step(x, x_prev, y_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_prev <= '0;
      y_prev <= '0;
    end else if (!en) begin
      x_prev <= '0;
      y_prev <= '0;
    end else if (stb) begin
      x_prev <= x;
      y_prev <= y;
    end
  end

  // After a disabled cycle the state is empty, so the stage is transparent
  AST_PASS_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (y == x)); // R4
endmodule

// File: rtl/wcap_status.sv
module wcap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  input  logic clr_bit,
  input  logic mask_wr,
  input  logic mask_bit,
  output logic ready,
  output logic mask_en,
  output logic irq_n
);
  logic clr_hit;
  assign clr_hit = clr_wr & clr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ready <= 1'b0;
    else if (set_evt) ready <= 1'b1;
    else if (clr_hit) ready <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_en <= 1'b0;
    else if (mask_wr) mask_en <= mask_bit;
  end

  assign irq_n = ~(ready & mask_en);

  AST_READY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ready); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !clr_hit |=> ready); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && !set_evt |=> !ready); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(set_evt) || $past(mask_wr))); // R8
endmodule

// File: rtl/wave_capture.sv
module wave_capture
  import wcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic [SMP_W-1:0]  smp_c,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_n
);
  smp_t smp_in   [NPH];
  smp_t filt_out [NPH];
  smp_t cap      [NPH];
  logic filt_en;
  logic ready, mask_en;
  logic cap_evt, cfg_wr, stat_wr, mask_wr, ph_rd_hit;
  logic unused_wdata;

  assign smp_in[0] = smp_a;
  assign smp_in[1] = smp_b;
  assign smp_in[2] = smp_c;

  // Named internal events
  assign cap_evt  = smp_valid;
  assign cfg_wr   = reg_wr && (reg_addr == ADR_CFG);
  assign stat_wr  = reg_wr && (reg_addr == ADR_STAT);
  assign mask_wr  = reg_wr && (reg_addr == ADR_MASK);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      filt_en <= 1'b1;
    else if (cfg_wr) filt_en <= reg_wdata[0];
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    wcap_dc_block u_dcb (
      .clk (clk),
      .rst_n (rst_n),
      .en  (filt_en),
      .stb (cap_evt),
      .x   (smp_in[p]),
      .y   (filt_out[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap[p] <= '0;
      else if (cap_evt) cap[p] <= filt_en ? filt_out[p] : smp_in[p];
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> $stable(cap[p])); // R2
    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt && !filt_en |=> cap[p] == $past(smp_in[p])); // R3
  end

  wcap_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (cap_evt),
    .clr_wr   (stat_wr),
    .clr_bit  (reg_wdata[RDY_BIT]),
    .mask_wr  (mask_wr),
    .mask_bit (reg_wdata[RDY_BIT]),
    .ready    (ready),
    .mask_en  (mask_en),
    .irq_n    (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    ph_rd_hit = 1'b0;
    case (reg_addr)
      ADR_CFG:  reg_rdata[0]       = filt_en;
      ADR_STAT: reg_rdata[RDY_BIT] = ready;
      ADR_MASK: reg_rdata[RDY_BIT] = mask_en;
      default:  ;
    endcase
    for (int p = 0; p < NPH; p++) begin
      if (reg_addr == ADDR_W'(int'(ADR_PH0) + p)) begin
        reg_rdata = sext(cap[p]);
        ph_rd_hit = 1'b1;
      end
    end
  end

  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ph_rd_hit |-> reg_rdata[REG_W-1:SMP_W] == {(REG_W-SMP_W){reg_rdata[SMP_W-1]}}); // R9
endmodule

// File: tb/wave_capture_tb.sv
module wave_capture_tb;
  import wcap_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [SMP_W-1:0]  smp_a = '0, smp_b = '0, smp_c = '0;
  logic [ADDR_W-1:0] drv_addr = '0, mon_addr = '0, reg_addr;
  logic              mon_active = 1'b0;
  logic              reg_wr = 1'b0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              irq_n;

  assign reg_addr = mon_active ? mon_addr : drv_addr;

  wave_capture u_dut (
    .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid),
    .smp_a (smp_a), .smp_b (smp_b), .smp_c (smp_c),
    .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .irq_n (irq_n)
  );

  int n_checks = 0, n_errs = 0;
  int sent_cnt = 0, done_cnt = 0;
  bit finished = 1'b0;
  logic [95:0] exp_q[$];
  string       tag_q[$];
  logic [95:0] last_exp = '0;
  int  m_xp[3], m_yp[3];
  bit  m_filt = 1'b1;
  localparam logic [31:0] RDY = 32'h0002_0000; // status/mask bit 17

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Leaky DC blocker restated with integer division and clamping
  function automatic int model_step(input int x, input int xp, input int yp);
    int div, leak, acc;
    div  = 1 << LEAK_SH;
    leak = (yp >= 0) ? yp / div : -((-yp + div - 1) / div);
    acc  = x - xp + yp - leak;
    if (acc > 8388607)  acc = 8388607;
    if (acc < -8388608) acc = -8388608;
    return acc;
  endfunction

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    drv_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == ADR_CFG) begin
      m_filt = d[0];
      if (!d[0]) for (int p = 0; p < 3; p++) begin m_xp[p] = 0; m_yp[p] = 0; end
    end
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    drv_addr = a;
    #1 d = reg_rdata;
  endtask

  // Driver: model the expected capture, push it, fire the strobe
  task automatic send(input int a, input int b, input int c, input bit clr, input string tag);
    int xs[3];
    int y;
    logic [95:0] e;
    xs[0] = a; xs[1] = b; xs[2] = c;
    for (int p = 0; p < 3; p++) begin
      if (m_filt) begin
        y = model_step(xs[p], m_xp[p], m_yp[p]);
        m_xp[p] = xs[p]; m_yp[p] = y;
      end else y = xs[p];
      e[p*32 +: 32] = y;
    end
    exp_q.push_back(e); tag_q.push_back(tag); last_exp = e;
    @(negedge clk);
    smp_a = a[SMP_W-1:0]; smp_b = b[SMP_W-1:0]; smp_c = c[SMP_W-1:0];
    smp_valid = 1'b1;
    if (clr) begin drv_addr = ADR_STAT; reg_wdata = RDY; reg_wr = 1'b1; end
    @(negedge clk);
    smp_valid = 1'b0; reg_wr = 1'b0;
    sent_cnt++;
    wait (done_cnt == sent_cnt);
  endtask

  // Monitor: read all three phases and compare against the scoreboard
  initial begin
    forever begin
      logic [95:0] e;
      string t;
      wait (sent_cnt > done_cnt);
      e = exp_q.pop_front(); t = tag_q.pop_front();
      mon_active = 1'b1;
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        mon_addr = ADDR_W'(int'(ADR_PH0) + p);
        #1 check(t, $sformatf("phase %0d sample", p), reg_rdata, e[p*32 +: 32]);
      end
      mon_active = 1'b0;
      done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int p = 0; p < 3; p++) begin m_xp[p] = 0; m_yp[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(ADR_CFG, d);  check("R1", "config", d, 32'h1);
    reg_read(ADR_STAT, d); check("R1", "status", d, 32'h0);
    reg_read(ADR_MASK, d); check("R1", "mask", d, 32'h0);
    for (int p = 0; p < 3; p++) begin
      reg_read(ADDR_W'(int'(ADR_PH0) + p), d); check("R1", "sample", d, 32'h0);
    end
    check("R1", "irq_n", {31'b0, irq_n}, 32'h1);

    // R9 unmapped addresses
    reg_read(3'd3, d); check("R9", "addr 3", d, 32'h0);
    reg_read(3'd7, d); check("R9", "addr 7", d, 32'h0);

    // R4 filtered captures, R9 sign extension via full 32-bit compare
    send(1000, -2000, 300000, 1'b0, "R4");
    reg_read(ADR_STAT, d); check("R6", "ready after strobe", d, RDY);
    check("R8", "irq_n masked", {31'b0, irq_n}, 32'h1);
    send(1500, -2500, -300000, 1'b0, "R4");
    send(-7000000, 5, 8000000, 1'b0, "R9");
    send(-7000000, 5, 8000000, 1'b0, "R4");

    // R2 hold without strobe
    @(negedge clk);
    smp_a = 24'h123456; smp_b = 24'h800001; smp_c = 24'h7FFFF0;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      reg_read(ADDR_W'(int'(ADR_PH0) + p), d); check("R2", "hold", d, last_exp[p*32 +: 32]);
    end

    // R5 saturation from a fresh state
    reg_write(ADR_CFG, 32'h0);
    reg_write(ADR_CFG, 32'h1);
    send(8388607, -8388608, 0, 1'b0, "R5");
    send(-8388608, 8388607, 0, 1'b0, "R5");
    send(8388607, -8388608, 0, 1'b0, "R5");

    // R3 bypass
    reg_write(ADR_CFG, 32'h0);
    reg_read(ADR_CFG, d); check("R9", "config readback", d, 32'h0);
    send(-1, 8388607, -8388608, 1'b0, "R3");
    send(42, -42, 4242424, 1'b0, "R3");

    // R4 re-enable starts from zero state
    reg_write(ADR_CFG, 32'h1);
    send(5000, -5000, 77, 1'b0, "R4");
    send(6000, -4000, 80, 1'b0, "R4");

    // R8 / R7 status, mask, interrupt
    reg_write(ADR_MASK, RDY);
    reg_read(ADR_MASK, d); check("R8", "mask readback", d, RDY);
    check("R8", "irq_n asserted", {31'b0, irq_n}, 32'h0);
    reg_write(ADR_STAT, 32'hFFFD_FFFF);
    reg_read(ADR_STAT, d); check("R7", "write zero keeps", d, RDY);
    reg_write(ADR_STAT, RDY);
    reg_read(ADR_STAT, d); check("R7", "w1c clears", d, 32'h0);
    check("R8", "irq_n released", {31'b0, irq_n}, 32'h1);
    send(11, 22, 33, 1'b1, "R7");
    reg_read(ADR_STAT, d); check("R7", "collision keeps set", d, RDY);
    check("R8", "irq_n after collision", {31'b0, irq_n}, 32'h0);
    reg_write(ADR_MASK, 32'h0);
    check("R8", "irq_n unmasked off", {31'b0, irq_n}, 32'h1);
    reg_read(ADR_STAT, d); check("R6", "still sticky", d, RDY);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule